// File: doc/BRIEF.md
# Block Write-Lock Register Bank

This block keeps one software lock register for each memory block of a flash array and merges it with two active-low hardware protect inputs. The result is a vector with one "write permitted" bit per block, used by the program/erase controller. Software reaches the registers through a byte-wide read/write port indexed by block number. Each register has two bits. The write-lock bit blocks program and erase on its block. The lock-down bit is sticky: once set, it freezes the whole register until the next reset.

The top boot block has its own protect input. A second input guards every other block. Either input, when low, forbids writes to the blocks it covers, whatever the software bits say. Readback shows only the software bits, so software never sees the state of the pins.

The controller opens an operation with a start pulse and a target block number. The block then samples that block's permission and holds it until the controller signals done. While an operation is running, register reads and writes are discarded.

Top module: `wlock_bank`

## Requirements
- R1: After reset every register reads 01h (write-lock set, lock-down clear), so every block is denied.
- R2: A write accepted by the port loads wdata bit 0 into the write-lock bit and wdata bit 1 into the lock-down bit of the indexed register. Readback bits 7..2 always read 0, and a read returns its data one cycle after reg_re.
- R3: While a register's lock-down bit (bit 1) is set, every write to that register is discarded. Only reset clears the lock-down bit.
- R4: While tbl_n is low, the top block (index NUM_BLOCKS-1) is denied whatever its write-lock bit holds. The other blocks are unaffected.
- R5: While wp_n is low, every block except the top one is denied whatever its write-lock bit holds. The top block is unaffected.
- R6: blk_perm[i] is 1 exactly when the write-lock bit of block i is 0 and the protect input covering block i is high.
- R7: Readback never reflects tbl_n or wp_n.
- R8: Any read or write presented while op_busy is 1, or in the same cycle as op_start, is discarded: the register content does not change and reg_rdata holds its previous value.
- R9: An index of NUM_BLOCKS or above is unused. It reads 00h, and writes to it change no register.
- R10: An op_start while idle sets op_busy on the next edge and loads op_grant with the target block's permission. op_grant holds that value until op_done, whatever the pins or registers do meanwhile. op_done clears both op_busy and op_grant on the next edge. While op_busy is 0, op_grant is 0. A target index of NUM_BLOCKS or above is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write request |
| reg_re | input | 1 | Register read request |
| reg_idx | input | IDX_W | Register index (block number) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| tbl_n | input | 1 | Top-block protect, active low |
| wp_n | input | 1 | Protect for all other blocks, active low |
| op_start | input | 1 | Program/erase start pulse |
| op_blk | input | IDX_W | Target block of the operation |
| op_done | input | 1 | Operation finished pulse |
| op_busy | output | 1 | Operation in progress |
| op_grant | output | 1 | Permission sampled at start, held while busy |
| blk_perm | output | NUM_BLOCKS | Live per-block write permission |

## Verification
The bench builds the bank with NUM_BLOCKS = 8, which gives a four-bit index. With that width, indexes 8 to 15 are real unused locations the port can reach, and the top block sits at index 7, next to ordinary blocks on both sides of the pin split. A small bank keeps the whole blk_perm vector in one byte. Each step can then be compared against a value worked out from the pin and software-bit rules, including the cases where a pin override and a lock-down freeze apply at once.

// File: rtl/wlock_pkg.sv
// Package: shared types and constants for the block write-lock bank.
// Assumes: register layout fixed at two live bits (write-lock, lock-down).
package wlock_pkg;

    // Software-visible state of one block's lock register.
    typedef struct packed {
        logic down;   // bit 1: freezes the register until reset
        logic wlock;  // bit 0: denies program/erase on the block
    } lock_bits_t;

    // Power-up / reset content: locked, not frozen.
    localparam lock_bits_t LOCK_RESET = '{down: 1'b0, wlock: 1'b1};

    // Width of the register port data.
    localparam int REG_DW = 8;

endpackage

// File: rtl/wlock_cell.sv
// Module: one lock register with a sticky lock-down bit.
// Assumes: wr_en already qualified by index match and access gating.
module wlock_cell
    import wlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  lock_bits_t wr_bits,
    output lock_bits_t bits
);

    // Register update: reset to locked; writes dropped once frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= LOCK_RESET;
        end else if (wr_en && !bits.down) begin
            bits <= wr_bits;
        end
    end

endmodule

// File: rtl/wlock_merge.sv
// Module: merges per-block write-lock bits with the two protect inputs.
// Assumes: the top block is index NUM_BLOCKS-1; pins are already synchronous.
module wlock_merge #(
    parameter int NUM_BLOCKS = 16
) (
    input  logic [NUM_BLOCKS-1:0] wlock,
    input  logic                  tbl_n,
    input  logic                  wp_n,
    output logic [NUM_BLOCKS-1:0] perm
);

    localparam int TOP = NUM_BLOCKS - 1;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        if (i == TOP) begin : g_top
            // Top block: guarded by its own pin.
            assign perm[i] = !wlock[i] && tbl_n;
        end else begin : g_rest
            // Remaining blocks: guarded by the shared pin.
            assign perm[i] = !wlock[i] && wp_n;
        end
    end

endmodule

// File: rtl/wlock_opcap.sv
// Module: tracks a program/erase operation and holds its sampled permission.
// Assumes: op_start ignored while busy; out-of-range target is denied.
module wlock_opcap #(
    parameter int NUM_BLOCKS = 16,
    parameter int IDX_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_start,
    input  logic [IDX_W-1:0]      op_blk,
    input  logic                  op_done,
    input  logic [NUM_BLOCKS-1:0] perm,
    output logic                  op_busy,
    output logic                  op_grant
);

    logic sel_perm;

    // Target permission lookup; unused indexes give 0.
    always_comb begin
        sel_perm = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (op_blk == IDX_W'(i)) sel_perm = perm[i];
        end
    end

    // Busy tracking and one-shot permission capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_busy  <= 1'b0;
            op_grant <= 1'b0;
        end else if (op_busy) begin
            if (op_done) begin
                op_busy  <= 1'b0;
                op_grant <= 1'b0;
            end
        end else if (op_start) begin
            op_busy  <= 1'b1;
            op_grant <= sel_perm;
        end
    end

endmodule

// File: rtl/wlock_bank.sv
// Module: top of the write-lock bank: register port, lock cells, pin merge
// and operation capture.
// Assumes: one access per cycle; reads and writes share one index.
module wlock_bank
    import wlock_pkg::*;
#(
    parameter  int NUM_BLOCKS = 16,
    localparam int IDX_W      = $clog2(NUM_BLOCKS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic                  reg_re,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [REG_DW-1:0]     reg_rdata,
    input  logic                  tbl_n,
    input  logic                  wp_n,
    input  logic                  op_start,
    input  logic [IDX_W-1:0]      op_blk,
    input  logic                  op_done,
    output logic                  op_busy,
    output logic                  op_grant,
    output logic [NUM_BLOCKS-1:0] blk_perm
);

    lock_bits_t            cell_bits [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0] wlock_vec;
    logic                  access_ok;
    lock_bits_t            wr_bits;
    lock_bits_t            rd_bits;
    logic                  unused_rsvd;

    // Reserved write bits carry no state.
    assign unused_rsvd = ^reg_wdata[REG_DW-1:2];

    // Port accesses pass only when no operation runs or starts.
    assign access_ok = !op_busy && !op_start;
    assign wr_bits   = lock_bits_t'(reg_wdata[1:0]);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cell
        logic hit;
        assign hit = reg_we && access_ok && (reg_idx == IDX_W'(i));
        wlock_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .wr_bits (wr_bits),
            .bits    (cell_bits[i])
        );
        assign wlock_vec[i] = cell_bits[i].wlock;
    end

    wlock_merge #(.NUM_BLOCKS(NUM_BLOCKS)) u_merge (
        .wlock (wlock_vec),
        .tbl_n (tbl_n),
        .wp_n  (wp_n),
        .perm  (blk_perm)
    );

    wlock_opcap #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_opcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_blk   (op_blk),
        .op_done  (op_done),
        .perm     (blk_perm),
        .op_busy  (op_busy),
        .op_grant (op_grant)
    );

    // Readback select: software bits only; unused indexes give zero.
    always_comb begin
        rd_bits = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (reg_idx == IDX_W'(i)) rd_bits = cell_bits[i];
        end
    end

    // Registered read data, held when no accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_re && access_ok) begin
            reg_rdata <= {{(REG_DW-2){1'b0}}, rd_bits};
        end
    end

endmodule

// File: rtl/wlock_bank_chk.sv
// Module: property checker for wlock_bank, attached with bind.
// Assumes: observes ports only.
module wlock_bank_chk #(
    parameter int NUM_BLOCKS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            reg_rdata,
    input logic                  tbl_n,
    input logic                  wp_n,
    input logic                  op_done,
    input logic                  op_busy,
    input logic                  op_grant,
    input logic [NUM_BLOCKS-1:0] blk_perm
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:2] == 6'd0);                                           // R2
    AST_TOP_PIN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_n |-> !blk_perm[NUM_BLOCKS-1]);                               // R4
    AST_REST_PIN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> (blk_perm[NUM_BLOCKS-2:0] == '0));                       // R5
    AST_BUSY_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |=> $stable(reg_rdata));                                   // R8
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !op_done) |=> $stable(op_grant));                      // R10
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> !op_grant);                                           // R10
    AST_DONE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && op_done) |=> !op_busy);                                // R10

endmodule

bind wlock_bank wlock_bank_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .tbl_n     (tbl_n),
    .wp_n      (wp_n),
    .op_done   (op_done),
    .op_busy   (op_busy),
    .op_grant  (op_grant),
    .blk_perm  (blk_perm)
);

// File: tb/test_wlock_bank.sv
`timescale 1ns/1ps
module test_wlock_bank;

    localparam int NB = 8;
    localparam int IW = $clog2(NB) + 1;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we, reg_re;
    logic [IW-1:0] reg_idx;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic          tbl_n, wp_n;
    logic          op_start, op_done;
    logic [IW-1:0] op_blk;
    logic          op_busy, op_grant;
    logic [NB-1:0] blk_perm;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done_flag = 1'b0;

    always #10 clk = ~clk;

    wlock_bank #(.NUM_BLOCKS(NB)) i_wlock_bank (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tbl_n(tbl_n), .wp_n(wp_n), .op_start(op_start), .op_blk(op_blk),
        .op_done(op_done), .op_busy(op_busy), .op_grant(op_grant),
        .blk_perm(blk_perm)
    );

    // Vector: we, re, idx[3:0], wdata, tbl_n, wp_n, exp rdata, exp perm
    localparam logic [31:0] VEC [NV] = '{
        {1'b0,1'b1,4'd0, 8'h00,1'b1,1'b1,8'h01,8'h00},  // R1 block 0 reset value
        {1'b0,1'b1,4'd7, 8'h00,1'b1,1'b1,8'h01,8'h00},  // R1 top block reset value
        {1'b1,1'b0,4'd0, 8'hFC,1'b1,1'b1,8'h01,8'h01},  // R2 unlock block 0
        {1'b0,1'b1,4'd0, 8'h00,1'b1,1'b1,8'h00,8'h01},  // R2 reserved bits read 0
        {1'b1,1'b0,4'd7, 8'h00,1'b1,1'b1,8'h00,8'h81},  // R6 unlock top
        {1'b0,1'b0,4'd0, 8'h00,1'b0,1'b1,8'h00,8'h01},  // R4 top pin low
        {1'b0,1'b0,4'd0, 8'h00,1'b1,1'b0,8'h00,8'h80},  // R5 rest pin low
        {1'b0,1'b1,4'd7, 8'h00,1'b0,1'b0,8'h00,8'h00},  // R7 pins hidden
        {1'b1,1'b0,4'd3, 8'h02,1'b1,1'b1,8'h00,8'h89},  // R3 freeze open
        {1'b1,1'b0,4'd3, 8'h01,1'b1,1'b1,8'h00,8'h89},  // R3 write dropped
        {1'b0,1'b1,4'd3, 8'h00,1'b1,1'b1,8'h02,8'h89},  // R3 readback frozen
        {1'b1,1'b0,4'd12,8'h00,1'b1,1'b1,8'h02,8'h89},  // R9 unused write
        {1'b0,1'b1,4'd12,8'h00,1'b1,1'b1,8'h00,8'h89},  // R9 unused read 00h
        {1'b1,1'b0,4'd5, 8'h01,1'b1,1'b1,8'h00,8'h89},  // R6 relock
        {1'b1,1'b0,4'd5, 8'h00,1'b1,1'b1,8'h00,8'hA9},  // R6 unlock block 5
        {1'b0,1'b1,4'd5, 8'h00,1'b1,1'b1,8'h00,8'hA9}   // R2 readback 00h
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_we = 1'b0; reg_re = 1'b0; op_start = 1'b0; op_done = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; idle(); reg_idx = '0; reg_wdata = '0;
        tbl_n = 1'b1; wp_n = 1'b1; op_blk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step();
        check("R1 rdata after reset", reg_rdata, 8'h00);
        check("R1 perm after reset", blk_perm, 8'h00);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {reg_we, reg_re, reg_idx, reg_wdata, tbl_n, wp_n} = VEC[v][31:16];
            step();
            check($sformatf("vector %0d rdata", v), reg_rdata, VEC[v][15:8]);
            check($sformatf("vector %0d perm", v), blk_perm, VEC[v][7:0]);
        end

        // R10/R8: start on open block 3 with a same-cycle write to block 0
        @(negedge clk); idle();
        op_start = 1'b1; op_blk = 4'd3;
        reg_we = 1'b1; reg_idx = 4'd0; reg_wdata = 8'h01;
        step();
        check("R10 busy after start", {7'd0, op_busy}, 8'h01);
        check("R10 grant open block", {7'd0, op_grant}, 8'h01);
        check("R8 write in start cycle dropped", blk_perm, 8'hA9);

        // R10: pin drop during the operation leaves the grant held
        @(negedge clk); idle(); wp_n = 1'b0;
        step();
        check("R5 rest pin low mid-op", blk_perm, 8'h80);
        check("R10 grant held", {7'd0, op_grant}, 8'h01);

        // R8: read and write while busy are dropped
        @(negedge clk); idle();
        reg_re = 1'b1; reg_idx = 4'd3;
        step();
        check("R8 read while busy holds rdata", reg_rdata, 8'h00);
        @(negedge clk); idle();
        reg_we = 1'b1; reg_idx = 4'd5; reg_wdata = 8'h01;
        step();

        @(negedge clk); idle(); op_done = 1'b1;
        step();
        check("R10 done clears busy", {7'd0, op_busy}, 8'h00);
        check("R10 done clears grant", {7'd0, op_grant}, 8'h00);

        @(negedge clk); idle(); wp_n = 1'b1; reg_re = 1'b1; reg_idx = 4'd5;
        step();
        check("R8 busy write to block 5 dropped", reg_rdata, 8'h00);
        check("R6 perm restored", blk_perm, 8'hA9);
        @(negedge clk); idle(); reg_re = 1'b1; reg_idx = 4'd0;
        step();
        check("R8 start-cycle write to block 0 dropped", reg_rdata, 8'h00);

        // R10: start on a locked block is denied
        @(negedge clk); idle(); op_start = 1'b1; op_blk = 4'd1;
        step();
        check("R10 locked target denied", {7'd0, op_grant}, 8'h00);
        check("R10 busy on locked target", {7'd0, op_busy}, 8'h01);
        @(negedge clk); idle(); op_done = 1'b1;
        step();

        // R10: top block with its pin low is denied
        @(negedge clk); idle(); tbl_n = 1'b0; op_start = 1'b1; op_blk = 4'd7;
        step();
        check("R4 top pin denies grant", {7'd0, op_grant}, 8'h00);
        @(negedge clk); idle(); tbl_n = 1'b1; op_done = 1'b1;
        step();

        // R9/R10: unused target index is denied
        @(negedge clk); idle(); op_start = 1'b1; op_blk = 4'd9;
        step();
        check("R9 unused target denied", {7'd0, op_grant}, 8'h00);
        @(negedge clk); idle(); op_done = 1'b1;
        step();

        // R1/R3: reset clears lock-down and relocks all
        @(negedge clk); idle(); rst_n = 1'b0;
        step(); step();
        @(negedge clk) rst_n = 1'b1;
        step();
        check("R1 perm after second reset", blk_perm, 8'h00);
        @(negedge clk); idle(); reg_re = 1'b1; reg_idx = 4'd3;
        step();
        check("R3 reset clears lock-down", reg_rdata, 8'h01);
        @(negedge clk); idle(); reg_we = 1'b1; reg_idx = 4'd3; reg_wdata = 8'h00;
        step();
        check("R3 register writable after reset", blk_perm, 8'h08);

        @(negedge clk); idle();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule